// File: doc/BRIEF.md
# Double-Buffered Angle Input Latch

This block takes a 16-bit natural-binary angle word from a host bus that is either 8 or 16 bits wide and presents it, held steady, to a downstream angle-to-sine/cosine converter. There are two byte-wide input stages, an upper one and a lower one, each with its own level-sensitive open control. Behind them sits a holding stage with a separate level-sensitive load control. A host on a narrow bus writes the two bytes in turn over the same eight lines and then loads the word. A host on a wide bus opens both stages at once and then loads.

Each control behaves as a transparent latch, modelled on a free-running system clock. While a control is high its stage follows its input. While it is low the stage keeps its value. The holding stage looks through any input stage that is open, so a word reaches the output on the clock edge after it is applied.

Every pin carries a "connected" flag. A control pin that is not connected reads as 1, and a data pin that is not connected reads as 0. With all controls left unconnected, the block is a plain one-cycle register from data to output. A built-in timing monitor measures the control pulses and the data stability windows in clock cycles. Each kind of violation sets its own sticky flag.

Top module: `angle_in_latch`

## Requirements
- R1: After reset `angle_out` is 0 and `viol_flags` is 0.
- R2: While the effective `hi_en` is 1, the upper stage takes `bus_data[15:8]`. While it is 0, the upper stage keeps its value.
- R3: While the effective `lo_en` is 1, the lower stage takes `bus_data[7:0]`. While it is 0, the lower stage keeps its value.
- R4: While the effective `load_en` is 1, the holding stage takes both stages, looking through any stage that is open. `angle_out` shows the result after the next rising clock edge. While `load_en` is 0, `angle_out` does not change.
- R5: A control with its `ctl_conn` bit at 0 reads as 1, whatever its pin value. `ctl_conn` bit 2 is `hi_en`, bit 1 is `lo_en` and bit 0 is `load_en`. With all three unconnected, `angle_out` equals the effective data one clock later.
- R6: A data bit whose `bus_data_conn` bit is 0 reads as 0.
- R7: If a byte control falls fewer than 100 cycles after it rose or after its byte last changed, `viol_flags` bit 0 is set.
- R8: If a byte changes within 25 cycles after its control fell, `viol_flags` bit 1 is set.
- R9: If `load_en` falls after being high for fewer than 75 cycles, `viol_flags` bit 2 is set.
- R10: If `load_en` rises fewer than 25 cycles after the effective data word last changed, `viol_flags` bit 3 is set.
- R11: Flag bits stay set until reset, and a sequence that meets all timing rules sets none.
- R12: In narrow-bus use, the two bytes are driven in turn on the same lines with `load_en` low. The output stays unchanged until the load, and the load then produces the combined word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 16 | Angle data, bit 15 is the MSB |
| bus_data_conn | input | 16 | Per-bit connected flag for `bus_data` |
| hi_en | input | 1 | Upper byte stage open control |
| lo_en | input | 1 | Lower byte stage open control |
| load_en | input | 1 | Holding stage load control |
| ctl_conn | input | 3 | Connected flags for {hi_en, lo_en, load_en} |
| angle_out | output | 16 | Held angle word to the converter |
| viol_flags | output | 4 | Sticky timing flags: {load setup, load width, byte hold, byte width} |

## Verification
The bench targets the following corner cases:
- Loading one byte while the other stage stays closed. A design that writes both halves together would corrupt the byte that was not written.
- Changing the data with all stages open but the load control low. A holding stage that is not frozen would let the new data leak to the output.
- Partially connected data and control masks. Swapping the pull-up and pull-down defaults shows up as wrong bits or a frozen output.
- Each timing rule broken by a clear margin, one rule per run with a reset between runs. A monitor that flags the wrong class, misses a violation or clears a flag early gives a mismatch in `viol_flags`.

// File: rtl/angle_latch_pkg.sv
package angle_latch_pkg;
   localparam int VIOL_W      = 4;
   localparam int VB_EN_WIDTH = 0;
   localparam int VB_EN_HOLD  = 1;
   localparam int VB_LD_WIDTH = 2;
   localparam int VB_LD_SETUP = 3;

   // Round a time in ns up to a whole number of clock cycles.
   function automatic int ns_to_cycles(input int ns, input int period_ps);
      return (ns * 1000 + period_ps - 1) / period_ps;
   endfunction
endpackage

// File: rtl/pin_defaults.sv
module pin_defaults #(
   parameter int DATA_W = 16,
   parameter int CTL_W  = 3
) (
   input  logic [DATA_W-1:0] data_raw,
   input  logic [DATA_W-1:0] data_conn,
   input  logic [CTL_W-1:0]  ctl_raw,
   input  logic [CTL_W-1:0]  ctl_conn,
   output logic [DATA_W-1:0] data_eff,
   output logic [CTL_W-1:0]  ctl_eff
);
   // Data pins fall back to a pull-down, control pins to a pull-up.
   for (genvar i = 0; i < DATA_W; i++) begin : g_dpin
      assign data_eff[i] = data_conn[i] ? data_raw[i] : 1'b0;
   end
   for (genvar j = 0; j < CTL_W; j++) begin : g_cpin
      assign ctl_eff[j] = ctl_conn[j] ? ctl_raw[j] : 1'b1;
   end
endmodule

// File: rtl/lane_stage.sv
module lane_stage #(
   parameter int LANE_W   = 8,
   parameter int EN_CYC   = 100,
   parameter int HOLD_CYC = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [LANE_W-1:0] din,
   output logic [LANE_W-1:0] view,
   output logic              viol_width,
   output logic              viol_hold
);
   localparam int CW = $clog2(EN_CYC + 2);
   localparam int HW = $clog2(HOLD_CYC + 2);

   logic [LANE_W-1:0] q_r, prev_din;
   logic              prev_en, armed;
   logic [CW-1:0]     open_cnt;
   logic [HW-1:0]     since_fall;
   logic              chg, fall;

   assign chg  = armed && (din != prev_din);
   assign fall = armed && prev_en && !en;

   // Transparent-latch view: an open stage passes its input straight on.
   assign view = en ? din : q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r        <= '0;
         prev_din   <= '0;
         prev_en    <= 1'b0;
         armed      <= 1'b0;
         open_cnt   <= '0;
         since_fall <= HW'(HOLD_CYC);
      end else begin
         armed    <= 1'b1;
         prev_din <= din;
         prev_en  <= en;
         if (en) q_r <= din;
         if (en) begin
            since_fall <= HW'(HOLD_CYC);
            if (chg || !prev_en)              open_cnt <= CW'(1);
            else if (open_cnt < CW'(EN_CYC))  open_cnt <= open_cnt + CW'(1);
         end else begin
            open_cnt <= '0;
            if (fall)                              since_fall <= HW'(1);
            else if (since_fall < HW'(HOLD_CYC))   since_fall <= since_fall + HW'(1);
         end
      end
   end

   assign viol_width = fall && (open_cnt < CW'(EN_CYC));
   assign viol_hold  = !en && chg && (fall || since_fall < HW'(HOLD_CYC));

   // R2 / R3: a closed stage keeps its contents, an open one takes its input.
   assert_lane_closed_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(q_r));
   assert_lane_open_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (q_r == $past(din)));
endmodule

// File: rtl/hold_stage.sv
module hold_stage #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] d,
   output logic [WORD_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

   assert_hold_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));
   assert_hold_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q == $past(d)));
endmodule

// File: rtl/load_monitor.sv
module load_monitor #(
   parameter int WORD_W    = 16,
   parameter int LOAD_CYC  = 75,
   parameter int SETUP_CYC = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word,
   output logic              viol_width,
   output logic              viol_setup
);
   localparam int LW = $clog2(LOAD_CYC + 2);
   localparam int SW = $clog2(SETUP_CYC + 2);

   logic [WORD_W-1:0] prev_word;
   logic              prev_ld, armed;
   logic [LW-1:0]     ld_cnt;
   logic [SW-1:0]     stable_cnt;
   logic              chg, rise, fall;

   assign chg  = armed && (word != prev_word);
   assign rise = armed && load && !prev_ld;
   assign fall = armed && prev_ld && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_word  <= '0;
         prev_ld    <= 1'b0;
         armed      <= 1'b0;
         ld_cnt     <= '0;
         stable_cnt <= '0;
      end else begin
         armed     <= 1'b1;
         prev_word <= word;
         prev_ld   <= load;
         if (chg)                                stable_cnt <= '0;
         else if (stable_cnt < SW'(SETUP_CYC))   stable_cnt <= stable_cnt + SW'(1);
         if (!load)                              ld_cnt <= '0;
         else if (rise)                          ld_cnt <= LW'(1);
         else if (ld_cnt < LW'(LOAD_CYC))        ld_cnt <= ld_cnt + LW'(1);
      end
   end

   assign viol_width = fall && (ld_cnt < LW'(LOAD_CYC));
   assign viol_setup = rise && (chg || stable_cnt < SW'(SETUP_CYC));
endmodule

// File: rtl/angle_in_latch.sv
module angle_in_latch
   import angle_latch_pkg::*;
#(
   parameter int WORD_W        = 16,
   parameter int CLK_PERIOD_PS = 8000,
   parameter int EN_MIN_NS     = 800,
   parameter int EN_HOLD_NS    = 200,
   parameter int LD_MIN_NS     = 600,
   parameter int LD_SETUP_NS   = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] bus_data,
   input  logic [WORD_W-1:0] bus_data_conn,
   input  logic              hi_en,
   input  logic              lo_en,
   input  logic              load_en,
   input  logic [2:0]        ctl_conn,
   output logic [WORD_W-1:0] angle_out,
   output logic [VIOL_W-1:0] viol_flags
);
   localparam int LANE_W    = WORD_W / 2;
   localparam int EN_CYC    = ns_to_cycles(EN_MIN_NS, CLK_PERIOD_PS);
   localparam int HOLD_CYC  = ns_to_cycles(EN_HOLD_NS, CLK_PERIOD_PS);
   localparam int LOAD_CYC  = ns_to_cycles(LD_MIN_NS, CLK_PERIOD_PS);
   localparam int SETUP_CYC = ns_to_cycles(LD_SETUP_NS, CLK_PERIOD_PS);

   if (WORD_W < 2 || (WORD_W % 2) != 0) begin : g_bad_width
      $error("angle_in_latch: WORD_W must be even and at least 2");
   end
   if (CLK_PERIOD_PS <= 0) begin : g_bad_period
      $error("angle_in_latch: CLK_PERIOD_PS must be positive");
   end

   logic [WORD_W-1:0] data_eff, staged;
   logic [2:0]        ctl_eff;
   logic [1:0]        lane_en, lane_vw, lane_vh;
   logic              ld_vw, ld_vs;

   pin_defaults #(.DATA_W(WORD_W), .CTL_W(3)) u_pins (
      .data_raw (bus_data),
      .data_conn(bus_data_conn),
      .ctl_raw  ({hi_en, lo_en, load_en}),
      .ctl_conn (ctl_conn),
      .data_eff (data_eff),
      .ctl_eff  (ctl_eff)
   );

   assign lane_en = ctl_eff[2:1];   // [1] upper byte, [0] lower byte

   for (genvar g = 0; g < 2; g++) begin : g_lane
      lane_stage #(.LANE_W(LANE_W), .EN_CYC(EN_CYC), .HOLD_CYC(HOLD_CYC)) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .en        (lane_en[g]),
         .din       (data_eff[g*LANE_W +: LANE_W]),
         .view      (staged[g*LANE_W +: LANE_W]),
         .viol_width(lane_vw[g]),
         .viol_hold (lane_vh[g])
      );
   end

   hold_stage #(.WORD_W(WORD_W)) u_hold (
      .clk  (clk),
      .rst_n(rst_n),
      .load (ctl_eff[0]),
      .d    (staged),
      .q    (angle_out)
   );

   load_monitor #(.WORD_W(WORD_W), .LOAD_CYC(LOAD_CYC), .SETUP_CYC(SETUP_CYC)) u_ldmon (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ctl_eff[0]),
      .word      (data_eff),
      .viol_width(ld_vw),
      .viol_setup(ld_vs)
   );

   logic [VIOL_W-1:0] new_viol;
   always_comb begin
      new_viol              = '0;
      new_viol[VB_EN_WIDTH] = |lane_vw;
      new_viol[VB_EN_HOLD]  = |lane_vh;
      new_viol[VB_LD_WIDTH] = ld_vw;
      new_viol[VB_LD_SETUP] = ld_vs;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) viol_flags <= '0;
      else        viol_flags <= viol_flags | new_viol;
   end

   // R11: a flag once raised never drops before reset.
   assert_flags_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((viol_flags & $past(viol_flags)) == $past(viol_flags)));
endmodule

// File: tb/tb_angle_in_latch.sv
module tb_angle_in_latch;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] bus_data, bus_data_conn;
   logic        hi_en, lo_en, load_en;
   logic [2:0]  ctl_conn;
   logic [15:0] angle_out;
   logic [3:0]  viol_flags;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   angle_in_latch dut (
      .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_data_conn(bus_data_conn),
      .hi_en(hi_en), .lo_en(lo_en), .load_en(load_en), .ctl_conn(ctl_conn),
      .angle_out(angle_out), .viol_flags(viol_flags)
   );

   // {data, connected mask, expected output}; all controls unconnected (R5, R6)
   localparam logic [47:0] VEC [6] = '{
      {16'h1234, 16'hFFFF, 16'h1234},
      {16'hFFFF, 16'hFF00, 16'hFF00},
      {16'h8001, 16'h7FFE, 16'h0000},
      {16'hABCD, 16'hFFF0, 16'hABC0},
      {16'h0F0F, 16'hFFFF, 16'h0F0F},
      {16'hFFFF, 16'h0000, 16'h0000}
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick(3);
      rst_n = 1'b1;
      tick(2);
   endtask

   task automatic lane_pulse(input logic h, input logic l, input int n);
      hi_en = h; lo_en = l;
      tick(n);
      hi_en = 1'b0; lo_en = 1'b0;
      tick(30);
   endtask

   task automatic do_load(input int n);
      load_en = 1'b1;
      tick(n);
      load_en = 1'b0;
      tick(2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; bus_data = '0; bus_data_conn = 16'hFFFF;
      hi_en = 1'b0; lo_en = 1'b0; load_en = 1'b0; ctl_conn = 3'b111;
      tick(1);
      do_reset();
      check("R1 reset angle", angle_out, 16'h0000);
      check("R1 reset flags", {12'h0, viol_flags}, 16'h0000);
      tick(30);

      // Transparent mode: controls unconnected, data walks the table
      ctl_conn = 3'b000;
      for (int i = 0; i < 6; i++) begin
         bus_data      = VEC[i][47:32];
         bus_data_conn = VEC[i][31:16];
         tick(1);
         check($sformatf("R5/R6 vector %0d", i), angle_out, VEC[i][15:0]);
      end

      // Single unconnected control: hi_en pin low but read as 1 (R5)
      bus_data = 16'hC300; bus_data_conn = 16'hFFFF;
      ctl_conn = 3'b111;
      do_reset();
      ctl_conn = 3'b011;
      tick(120);
      ctl_conn = 3'b111;
      tick(30);
      do_load(80);
      check("R5 unconnected hi_en reads 1", angle_out, 16'hC300);
      check("R5 no flags", {12'h0, viol_flags}, 16'h0000);

      // Directed 16-bit bus flow
      bus_data = 16'h0000;
      do_reset();
      bus_data = 16'hA55A;
      tick(5);
      lane_pulse(1'b1, 1'b1, 110);
      do_load(80);
      check("R4 wide load", angle_out, 16'hA55A);

      bus_data = 16'h1234;
      tick(5);
      lane_pulse(1'b1, 1'b1, 110);
      check("R4 frozen while load low", angle_out, 16'hA55A);
      do_load(80);
      check("R4 second load", angle_out, 16'h1234);

      bus_data = 16'h7E81;
      tick(5);
      lane_pulse(1'b1, 1'b0, 110);
      do_load(80);
      check("R2 upper byte only", angle_out, 16'h7E34);

      bus_data = 16'h00C3;
      tick(5);
      lane_pulse(1'b0, 1'b1, 110);
      do_load(80);
      check("R3 lower byte only", angle_out, 16'h7EC3);

      // Narrow bus: same eight lines, bytes in turn, load low (R12)
      bus_data = 16'h5B5B;
      tick(5);
      lane_pulse(1'b1, 1'b0, 110);
      bus_data = 16'h2626;
      tick(5);
      lane_pulse(1'b0, 1'b1, 110);
      check("R12 output unchanged before load", angle_out, 16'h7EC3);
      do_load(80);
      check("R12 combined word", angle_out, 16'h5B26);
      check("R11 clean run sets no flag", {12'h0, viol_flags}, 16'h0000);

      // R7: short byte pulse
      do_reset();
      bus_data = 16'h1111;
      tick(5);
      lane_pulse(1'b1, 1'b0, 10);
      check("R7 short enable flag", {12'h0, viol_flags}, 16'h0001);
      bus_data = 16'h2222;
      tick(5);
      lane_pulse(1'b1, 1'b1, 110);
      check("R11 flag stays set", {12'h0, viol_flags}, 16'h0001);
      do_reset();
      check("R1 reset clears flags", {12'h0, viol_flags}, 16'h0000);

      // R8: data change inside hold window
      bus_data = 16'h3333;
      tick(5);
      hi_en = 1'b1; tick(110); hi_en = 1'b0;
      tick(5);
      bus_data = 16'h4433;
      tick(2);
      check("R8 hold window flag", {12'h0, viol_flags}, 16'h0002);

      // R9: short load pulse
      do_reset();
      tick(40);
      do_load(20);
      check("R9 short load flag", {12'h0, viol_flags}, 16'h0004);

      // R10: load raised too soon after a data change
      do_reset();
      tick(40);
      bus_data = 16'h5555;
      tick(5);
      do_load(80);
      check("R10 setup flag", {12'h0, viol_flags}, 16'h0008);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule